// File: doc/BRIEF.md
# Byte-Wide Host Port Slave

This block gives an external processor access to a 16-bit internal memory over an 8-bit host bus. Each 16-bit word moves as a pair of byte cycles. A byte-select input tells the port whether a cycle carries the first byte, which is the high half, or the second byte, which is the low half. The host loads the word address through an address strobe, which latches the byte on the host data bus. It then moves data with chip select and either of two data strobes. A read/write input sets the direction of each cycle. The internal side is a request/acknowledge memory port. A request is held until the memory acknowledges it.

A strap input is sampled once, on the first clock edge after reset is released. If the strap is high, the port is enabled. If it is low, the port stays silent until the next reset: host strobes do nothing and no memory requests are issued. The host interrupt output is held high during reset. When the port is enabled, it carries an inverted, registered copy of the core's interrupt request. When the port is disabled, it carries a timer signal instead. All host pins are sampled on the rising edge of the system clock. A data cycle or address cycle starts on the first edge at which its qualified strobe is seen active.

Top module: `hbb_top`

## Requirements
- R1: The port-enable state is taken from `enStrap` at the first clock edge after `rstN` rises. Later changes of `enStrap` have no effect until the next reset.
- R2: When the port is disabled, `hostRdy` stays 0, `memReq` stays 0, and host write cycles leave memory unchanged.
- R3: While `rstN` is low, `hostIntN` is 1. When the port is enabled, `hostIntN` equals the inverse of `coreIrq` one clock later. When the port is disabled, `hostIntN` follows `timerIn`.
- R4: When `hostCsN` is 0 and `hostAsN` goes low, the address register loads `hostDin[ADDR_W-1:0]`. An address strobe with `hostCsN` high is ignored.
- R5: A write cycle (`hostRdWr`=0) with `hostByteSel`=0 stores the byte in a staging register and does not raise `memReq`.
- R6: A write cycle with `hostByteSel`=1 raises `memReq` with `memWe`=1 one clock after the strobe edge. The write carries `memWdata` = {staged byte, current byte} and `memAddr` = the latched address. It writes exactly one word.
- R7: A read cycle (`hostRdWr`=1) with `hostByteSel`=0 raises `memReq` with `memWe`=0. On the acknowledge edge, `hostDout` takes bits [15:8] of `memRdata`.
- R8: A read cycle with `hostByteSel`=1 puts bits [7:0] of the word captured in R7 on `hostDout`. It issues no memory request, so later changes to memory do not affect the value returned.
- R9: `hostRdy` is 1 only when the port is enabled and no memory access is pending. It falls in the clock after a memory access starts and rises in the clock after `memAck`.
- R10: Data strobes with `hostCsN` high are ignored: no request, no staging, no output change.
- R11: While `memReq` waits for `memAck`, `memAddr`, `memWe` and `memWdata` stay stable. `memReq` drops in the clock after `memAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enStrap | input | 1 | Port-enable strap, sampled after reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostDs1N | input | 1 | Host data strobe 1, active low |
| hostDs2N | input | 1 | Host data strobe 2, active low |
| hostAsN | input | 1 | Host address strobe, active low |
| hostRdWr | input | 1 | 1 = host reads, 0 = host writes |
| hostByteSel | input | 1 | 0 = first (high) byte, 1 = second (low) byte |
| hostDin | input | BYTE_W | Host write data / address |
| hostDout | output | BYTE_W | Host read data |
| hostRdy | output | 1 | Port ready for the next transfer |
| hostIntN | output | 1 | Host interrupt or timer output |
| coreIrq | input | 1 | Core interrupt request to the host |
| timerIn | input | 1 | Timer signal routed out when the port is disabled |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = memory write |
| memAddr | output | ADDR_W | Memory word address |
| memWdata | output | 2*BYTE_W | Memory write word |
| memRdata | input | 2*BYTE_W | Memory read word, valid with memAck |
| memAck | input | 1 | One-cycle memory acknowledge |

## Verification
The strobe edge is registered once. `memReq`, `memWe` and the loss of `hostRdy` therefore appear one clock after the edge, and the bench samples them at the falling edge just after that clock. Staging, address loads and the second-byte read output are also due one clock after the strobe edge. `hostDout` for a first-byte read and the return of `hostRdy` are due on the acknowledge edge, so the bench polls `hostRdy` at falling edges before it checks the data. `hostIntN` lags `coreIrq` by one clock. It follows `timerIn` and the reset level without delay, so the bench checks those in the same half-cycle as the stimulus.

// File: rtl/hbb_pkg.sv
package hbb_pkg;

  typedef struct packed {
    logic loadAddr;
    logic loadStage;
    logic issueWrite;
    logic issueRead;
    logic captureRead;
    logic emitLow;
  } hbbStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2
  } hbbState_t;

endpackage

// File: rtl/hbb_ctrl.sv
module hbb_ctrl
  import hbb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enStrap,
  input  logic        hostCsN,
  input  logic        hostDs1N,
  input  logic        hostDs2N,
  input  logic        hostAsN,
  input  logic        hostRdWr,
  input  logic        hostByteSel,
  input  logic        memAck,
  output hbbStrobes_t strb,
  output logic        memReq,
  output logic        memWe,
  output logic        hostRdy,
  output logic        portEn
);

  hbbState_t state;
  logic strapDone;
  logic prevData;
  logic prevAddr;

  logic selOk;
  logic dataAct;
  logic addrAct;
  logic dataEdge;
  logic addrEdge;
  logic live;

  // A cycle is qualified only with chip select low.
  assign selOk    = ~hostCsN;
  assign dataAct  = selOk & (~hostDs1N | ~hostDs2N);
  assign addrAct  = selOk & ~hostAsN;
  assign dataEdge = dataAct & ~prevData;
  assign addrEdge = addrAct & ~prevAddr;
  assign live     = portEn & (state == ST_IDLE);

  always_comb begin
    strb = '0;
    if (live && addrEdge) strb.loadAddr = 1'b1;
    if (live && dataEdge) begin
      case ({hostRdWr, hostByteSel})
        2'b00:   strb.loadStage  = 1'b1;
        2'b01:   strb.issueWrite = 1'b1;
        2'b10:   strb.issueRead  = 1'b1;
        default: strb.emitLow    = 1'b1;
      endcase
    end
    strb.captureRead = (state == ST_RD) & memAck;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      strapDone <= 1'b0;
      portEn    <= 1'b0;
      prevData  <= 1'b0;
      prevAddr  <= 1'b0;
    end else begin
      if (!strapDone) begin
        strapDone <= 1'b1;
        portEn    <= enStrap;
      end
      prevData <= dataAct;
      prevAddr <= addrAct;
      case (state)
        ST_IDLE: begin
          if (strb.issueWrite)     state <= ST_WR;
          else if (strb.issueRead) state <= ST_RD;
        end
        ST_WR, ST_RD: begin
          if (memAck) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq  = (state != ST_IDLE);
  assign memWe   = (state == ST_WR);
  assign hostRdy = live;

endmodule

// File: rtl/hbb_datapath.sv
module hbb_datapath
  import hbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  hbbStrobes_t           strb,
  input  logic                  portEn,
  input  logic [BYTE_W-1:0]     hostDin,
  input  logic [2*BYTE_W-1:0]   memRdata,
  input  logic                  coreIrq,
  input  logic                  timerIn,
  output logic [BYTE_W-1:0]     hostDout,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [2*BYTE_W-1:0]   memWdata,
  output logic                  hostIntN
);

  localparam int WORD_W = 2 * BYTE_W;
  localparam int LOAD_W = (ADDR_W < BYTE_W) ? ADDR_W : BYTE_W;

  logic [ADDR_W-1:0] addrReg;
  logic [BYTE_W-1:0] stageReg;
  logic [WORD_W-1:0] wdataReg;
  logic [WORD_W-1:0] holdReg;
  logic [BYTE_W-1:0] doutReg;
  logic              intReg;
  logic [ADDR_W-1:0] addrNext;

  // Address loads from the byte bus; a wider address is zero-extended.
  generate
    if (ADDR_W > BYTE_W) begin : g_wideAddr
      assign addrNext = {{(ADDR_W-BYTE_W){1'b0}}, hostDin};
    end else begin : g_narrowAddr
      assign addrNext = hostDin[LOAD_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg  <= '0;
      stageReg <= '0;
      wdataReg <= '0;
      holdReg  <= '0;
      doutReg  <= '0;
      intReg   <= 1'b1;
    end else begin
      intReg <= ~coreIrq;
      if (strb.loadAddr)    addrReg  <= addrNext;
      if (strb.loadStage)   stageReg <= hostDin;
      if (strb.issueWrite)  wdataReg <= {stageReg, hostDin};
      if (strb.captureRead) begin
        holdReg <= memRdata;
        doutReg <= memRdata[WORD_W-1:BYTE_W];
      end
      if (strb.emitLow)     doutReg  <= holdReg[BYTE_W-1:0];
    end
  end

  assign hostDout = doutReg;
  assign memAddr  = addrReg;
  assign memWdata = wdataReg;
  assign hostIntN = !rstN ? 1'b1 : (portEn ? intReg : timerIn);

endmodule

// File: rtl/hbb_top.sv
module hbb_top
  import hbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enStrap,
  input  logic                hostCsN,
  input  logic                hostDs1N,
  input  logic                hostDs2N,
  input  logic                hostAsN,
  input  logic                hostRdWr,
  input  logic                hostByteSel,
  input  logic [BYTE_W-1:0]   hostDin,
  output logic [BYTE_W-1:0]   hostDout,
  output logic                hostRdy,
  output logic                hostIntN,
  input  logic                coreIrq,
  input  logic                timerIn,
  output logic                memReq,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*BYTE_W-1:0] memWdata,
  input  logic [2*BYTE_W-1:0] memRdata,
  input  logic                memAck
);

  hbbStrobes_t strb;
  logic        portEn;

  hbb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enStrap     (enStrap),
    .hostCsN     (hostCsN),
    .hostDs1N    (hostDs1N),
    .hostDs2N    (hostDs2N),
    .hostAsN     (hostAsN),
    .hostRdWr    (hostRdWr),
    .hostByteSel (hostByteSel),
    .memAck      (memAck),
    .strb        (strb),
    .memReq      (memReq),
    .memWe       (memWe),
    .hostRdy     (hostRdy),
    .portEn      (portEn)
  );

  hbb_datapath #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .portEn   (portEn),
    .hostDin  (hostDin),
    .memRdata (memRdata),
    .coreIrq  (coreIrq),
    .timerIn  (timerIn),
    .hostDout (hostDout),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .hostIntN (hostIntN)
  );

endmodule

// File: rtl/hbb_chk.sv
module hbb_chk #(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                portEn,
  input logic                hostRdy,
  input logic                hostIntN,
  input logic                memReq,
  input logic                memWe,
  input logic                memAck,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [2*BYTE_W-1:0] memWdata
);

  logic seenEdge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenEdge <= 1'b0;
    else       seenEdge <= 1'b1;
  end

  // R3
  always @(posedge clk) begin
    if (rstN === 1'b0) begin
      int_reset_chk: assert (hostIntN === 1'b1);
    end
  end

  // R9
  rdy_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !hostRdy);

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && !portEn) |-> (!memReq && !hostRdy));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R11
  req_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck) |=> !memReq);

  // R1
  strap_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge |=> $stable(portEn));

endmodule

bind hbb_top hbb_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .portEn   (portEn),
  .hostRdy  (hostRdy),
  .hostIntN (hostIntN),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAck   (memAck),
  .memAddr  (memAddr),
  .memWdata (memWdata)
);

// File: tb/hbb_top_tb.sv
module hbb_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int BYTE_W = 8;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enStrap = 1'b1;
  logic hostCsN = 1'b1;
  logic hostDs1N = 1'b1;
  logic hostDs2N = 1'b1;
  logic hostAsN = 1'b1;
  logic hostRdWr = 1'b0;
  logic hostByteSel = 1'b0;
  logic [BYTE_W-1:0] hostDin = '0;
  logic [BYTE_W-1:0] hostDout;
  logic hostRdy;
  logic hostIntN;
  logic coreIrq = 1'b0;
  logic timerIn = 1'b0;
  logic memReq;
  logic memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [15:0] memWdata;
  logic [15:0] memRdata = '0;
  logic memAck = 1'b0;

  logic pokeEn = 1'b0;
  logic [ADDR_W-1:0] pokeAddr = '0;
  logic [15:0] pokeData = '0;
  logic [15:0] mem [256];
  int lat = 0;
  int accCount = 0;
  int wrCount = 0;
  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbb_top #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dut (
    .clk(clk), .rstN(rstN), .enStrap(enStrap), .hostCsN(hostCsN),
    .hostDs1N(hostDs1N), .hostDs2N(hostDs2N), .hostAsN(hostAsN),
    .hostRdWr(hostRdWr), .hostByteSel(hostByteSel), .hostDin(hostDin),
    .hostDout(hostDout), .hostRdy(hostRdy), .hostIntN(hostIntN),
    .coreIrq(coreIrq), .timerIn(timerIn), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  // Memory model: acknowledge LAT cycles into a request.
  always @(posedge clk) begin
    memAck <= 1'b0;
    if (pokeEn) mem[pokeAddr] <= pokeData;
    if (memReq && !memAck) begin
      if (lat == LAT-1) begin
        lat <= 0;
        memAck <= 1'b1;
        accCount <= accCount + 1;
        memRdata <= mem[memAddr];
        if (memWe) begin
          mem[memAddr] <= memWdata;
          wrCount <= wrCount + 1;
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  endtask

  task automatic poke(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    pokeEn = 1'b1; pokeAddr = a; pokeData = d;
    @(negedge clk);
    pokeEn = 1'b0;
  endtask

  task automatic waitReady();
    for (int i = 0; i < 40; i++) begin
      if (hostRdy) break;
      @(negedge clk);
    end
  endtask

  // One host data cycle; returns at the falling edge after the strobe edge.
  task automatic hostCycle(input logic cs, input logic rd, input logic bsel,
                           input logic [BYTE_W-1:0] d, input logic useDs2);
    @(negedge clk);
    hostCsN = ~cs; hostRdWr = rd; hostByteSel = bsel; hostDin = d;
    if (useDs2) hostDs2N = 1'b0; else hostDs1N = 1'b0;
    @(negedge clk);
    hostDs1N = 1'b1; hostDs2N = 1'b1; hostCsN = 1'b1;
  endtask

  task automatic addrCycle(input logic cs, input logic [BYTE_W-1:0] a);
    @(negedge clk);
    hostCsN = ~cs; hostAsN = 1'b0; hostDin = a;
    @(negedge clk);
    hostAsN = 1'b1; hostCsN = 1'b1;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; enStrap = strap;
    repeat (2) @(negedge clk);
    check("R3 int high in reset", hostIntN, 1'b1);
    check("R9 rdy low in reset", hostRdy, 1'b0);
    check("R11 no req in reset", memReq, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testWrite();
    int w0;
    addrCycle(1'b1, 8'h12);
    w0 = wrCount;
    hostCycle(1'b1, 1'b0, 1'b0, 8'hAB, 1'b0);
    check("R5 no req after first byte", memReq, 1'b0);
    check("R5 ready stays", hostRdy, 1'b1);
    hostCycle(1'b1, 1'b0, 1'b1, 8'hCD, 1'b1);
    check("R6 req raised", memReq, 1'b1);
    check("R6 write enable", memWe, 1'b1);
    check("R4 address latched", memAddr, 8'h12);
    check("R6 word order", memWdata, 16'hABCD);
    check("R9 rdy low while busy", hostRdy, 1'b0);
    waitReady();
    check("R9 rdy back after ack", hostRdy, 1'b1);
    check("R6 one write", wrCount - w0, 1);
    check("R6 memory content", mem[8'h12], 16'hABCD);
  endtask

  task automatic testRead();
    int a0;
    poke(8'h34, 16'h5A3C);
    addrCycle(1'b1, 8'h34);
    hostCycle(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    check("R7 read req", memReq, 1'b1);
    check("R7 read not write", memWe, 1'b0);
    waitReady();
    check("R7 high byte", hostDout, 8'h5A);
    a0 = accCount;
    poke(8'h34, 16'h0000);
    hostCycle(1'b1, 1'b1, 1'b1, 8'h00, 1'b1);
    check("R8 no req second byte", memReq, 1'b0);
    check("R8 low byte from hold", hostDout, 8'h3C);
    repeat (LAT + 2) @(negedge clk);
    check("R8 no access", accCount - a0, 0);
  endtask

  task automatic testCsHigh();
    int w0;
    logic [BYTE_W-1:0] d0;
    w0 = wrCount;
    d0 = hostDout;
    hostCycle(1'b0, 1'b0, 1'b0, 8'h11, 1'b0);
    hostCycle(1'b0, 1'b0, 1'b1, 8'h22, 1'b0);
    check("R10 no req with cs high", memReq, 1'b0);
    hostCycle(1'b0, 1'b1, 1'b1, 8'h00, 1'b0);
    check("R10 dout unchanged", hostDout, d0);
    addrCycle(1'b0, 8'h77);
    hostCycle(1'b1, 1'b0, 1'b0, 8'h99, 1'b0);
    hostCycle(1'b1, 1'b0, 1'b1, 8'h88, 1'b0);
    check("R4 cs-high address ignored", memAddr, 8'h34);
    check("R10 staged byte untouched by cs-high cycle", memWdata, 16'h9988);
    waitReady();
    check("R10 only one write", wrCount - w0, 1);
  endtask

  task automatic testIrq();
    @(negedge clk);
    coreIrq = 1'b1;
    check("R3 one-cycle lag", hostIntN, 1'b1);
    @(negedge clk);
    check("R3 irq asserted", hostIntN, 1'b0);
    coreIrq = 1'b0;
    timerIn = 1'b1;
    @(negedge clk);
    check("R3 irq released, timer ignored", hostIntN, 1'b1);
    timerIn = 1'b0;
  endtask

  task automatic testStrapLock();
    enStrap = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 strap change ignored", hostRdy, 1'b1);
    enStrap = 1'b1;
  endtask

  task automatic testDisabled();
    int w0;
    doReset(1'b0);
    enStrap = 1'b1;
    @(negedge clk);
    check("R1 late strap ignored", hostRdy, 1'b0);
    check("R2 rdy low", hostRdy, 1'b0);
    w0 = wrCount;
    addrCycle(1'b1, 8'h40);
    hostCycle(1'b1, 1'b0, 1'b0, 8'hEE, 1'b0);
    hostCycle(1'b1, 1'b0, 1'b1, 8'hFF, 1'b0);
    check("R2 no req", memReq, 1'b0);
    repeat (LAT + 2) @(negedge clk);
    check("R2 no write", wrCount - w0, 0);
    timerIn = 1'b1;
    #1;
    check("R3 timer routed high", hostIntN, 1'b1);
    timerIn = 1'b0;
    #1;
    check("R3 timer routed low", hostIntN, 1'b0);
    coreIrq = 1'b1;
    @(negedge clk);
    check("R3 irq not routed when disabled", hostIntN, 1'b0);
    coreIrq = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog act=expired exp=done");
    finish();
  end

  initial begin
    doReset(1'b1);
    check("R1 enabled by strap", hostRdy, 1'b1);
    check("R3 idle int level", hostIntN, 1'b1);
    testWrite();
    testRead();
    testCsHigh();
    testIrq();
    testStrapLock();
    testDisabled();
    doReset(1'b1);
    check("R1 re-enabled after reset", hostRdy, 1'b1);
    finish();
  end

endmodule